// File: doc/BRIEF.md
# Reference Clock Divider with Controller Clock and Slow Timebase

This block takes a single reference oscillator clock (7.2 MHz in the intended system) and derives two signals from it with synchronous counters. The first is a controller clock at one eighteenth of the reference rate, 400 kHz. It is high for two thirds of each period and starts toggling on the first reference edge after reset is released, so the controller has a clock before it has written any control data.

The second signal is a slow square-wave timebase. The controller clock's period-wrap pulse feeds a second counter that toggles a square wave once every `CTL_DIV * TB_PERIODS` reference cycles. With the defaults this is 450,000 cycles, which gives 8 Hz. An enable bit from the surrounding control register gates the timebase onto its output pin. The counter behind it keeps running while the output is gated, so re-enabling it does not shift its phase.

Top module: `clkgen_top`

## Requirements
- R1: While `rst_n` is sampled low on a rising edge of `clk_ref`, the next state drives `ctl_clk_o` high and `tick_o` low, and both counters return to zero.
- R2: Let k be the number of `clk_ref` rising edges since the last edge that sampled `rst_n` low. Then `ctl_clk_o` is high exactly when (k mod `CTL_DIV`) < `CTL_HIGH`. With the defaults that is 12 cycles high and 6 low in an 18-cycle period.
- R3: The controller clock runs from reset release regardless of the value of `tb_en`.
- R4: The internal timebase square wave equals floor(k / (`CTL_DIV` * `TB_PERIODS`)) mod 2. It starts low and each level lasts `CTL_DIV` * `TB_PERIODS` cycles, which is 450,000 cycles by default (8 Hz from 7.2 MHz).
- R5: `tick_o` equals the timebase square wave ANDed with `tb_en`. It is low in the same cycle that `tb_en` is 0.
- R6: Changing `tb_en` has no effect on the timebase phase. After re-enabling, `tick_o` follows the R4 formula as if the output had never been gated.
- R7: Asserting reset in the middle of a run restarts both outputs from phase zero, as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tb_en | input | 1 | Timebase output enable from the control register |
| ctl_clk_o | output | 1 | Controller clock, `CTL_HIGH` of `CTL_DIV` cycles high |
| tick_o | output | 1 | Gated slow timebase square wave |

## Verification
A corrupted phase count shows up on `ctl_clk_o` within one 18-cycle period, as a high or low run of the wrong length. A corrupted timebase count or toggle condition moves the next `tick_o` edge away from the multiple of `CTL_DIV * TB_PERIODS` where it should fall, so it appears at the first timebase half-period. The bench shrinks `TB_PERIODS` so that several such edges occur in a short run. It checks both outputs on every cycle against the k-based formulas, so a fault shows within the cycle it first affects.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    // Reference cycles per controller clock period (7.2 MHz / 400 kHz)
    localparam int unsigned CTL_DIV_DEF    = 18;
    // Reference cycles the controller clock stays high in each period
    localparam int unsigned CTL_HIGH_DEF   = 12;
    // Controller periods per timebase half-period (18 * 25000 = 450000)
    localparam int unsigned TB_PERIODS_DEF = 25000;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/clkgen_phase.sv
module clkgen_phase #(
    parameter int unsigned DIV  = clkgen_pkg::CTL_DIV_DEF,
    parameter int unsigned HIGH = clkgen_pkg::CTL_HIGH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    output logic clk_o,
    output logic wrap_o
);
    localparam int unsigned W = clkgen_pkg::cnt_width(DIV);
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    localparam logic [W-1:0] HI   = W'(HIGH);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         lvl;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.lvl = (st_d.cnt < HI);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lvl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o  = st_q.lvl;
    assign wrap_o = (st_q.cnt == LAST);

    // R2: phase counter never leaves its period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R2: a period wrap is followed by the start of the high phase
    p_wrap_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.cnt == '0) && clk_o);
    // R2: high phase ends exactly at the configured count
    p_fall_point_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_o) |-> st_q.cnt == HI);
endmodule

// File: rtl/clkgen_tbase.sv
module clkgen_tbase #(
    parameter int unsigned PERIODS = clkgen_pkg::TB_PERIODS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic sq_o
);
    localparam int unsigned W = clkgen_pkg::cnt_width(PERIODS);
    localparam logic [W-1:0] LAST = W'(PERIODS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         sq;
    } tbase_t;

    tbase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.sq  = ~st_q.sq;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sq_o = st_q.sq;

    // R4: period count stays within its half-period
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R4: square wave flips only after the last period of a half-period
    p_toggle_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sq != $past(st_q.sq)) |-> $past(adv_i && (st_q.cnt == LAST)));
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
    parameter int unsigned CTL_DIV    = clkgen_pkg::CTL_DIV_DEF,
    parameter int unsigned CTL_HIGH   = clkgen_pkg::CTL_HIGH_DEF,
    parameter int unsigned TB_PERIODS = clkgen_pkg::TB_PERIODS_DEF
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic tb_en,
    output logic ctl_clk_o,
    output logic tick_o
);
    logic wrap_w;
    logic sq_w;

    clkgen_phase #(
        .DIV  (CTL_DIV),
        .HIGH (CTL_HIGH)
    ) u_phase (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .clk_o  (ctl_clk_o),
        .wrap_o (wrap_w)
    );

    clkgen_tbase #(
        .PERIODS (TB_PERIODS)
    ) u_tbase (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .adv_i (wrap_w),
        .sq_o  (sq_w)
    );

    assign tick_o = sq_w & tb_en;

    // R4: timebase edges land on the start of a controller clock period
    p_tb_aligned_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (sq_w != $past(sq_w)) |-> ctl_clk_o);
    // R3: controller clock keeps toggling; never stuck high past its period
    p_ctl_runs_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        wrap_w |-> !ctl_clk_o);
endmodule

// File: tb/clkgen_top_test.sv
module clkgen_top_test;
    localparam int unsigned DIV  = 18;
    localparam int unsigned HIGH = 12;
    localparam int unsigned PER  = 3;
    localparam int unsigned HALF = DIV * PER;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_en = 1'b0;
    logic ctl_clk_o;
    logic tick_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    clkgen_top #(
        .CTL_DIV    (DIV),
        .CTL_HIGH   (HIGH),
        .TB_PERIODS (PER)
    ) uut (
        .clk_ref   (clk_ref_w),
        .rst_n     (rst_n),
        .tb_en     (tb_en),
        .ctl_clk_o (ctl_clk_o),
        .tick_o    (tick_o)
    );
    wire clk_ref_w = clk;

    task automatic chk(input string req, input logic act, input logic exp, input int k);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
        end
    endtask

    function automatic logic exp_ctl(input int k);
        return (k % DIV) < HIGH;
    endfunction

    function automatic logic exp_sq(input int k);
        return ((k / HALF) % 2) == 1;
    endfunction

    // hold reset for several edges; return at a negedge where k = 0
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state visible at the ports
        chk("R1 ctl_clk_o in reset", ctl_clk_o, 1'b1, -1);
        chk("R1 tick_o in reset", tick_o, 1'b0, -1);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        tb_en = 1'b1;
        do_reset();
        chk("R1 ctl_clk_o after release", ctl_clk_o, 1'b1, 0);
        chk("R1 tick_o after release", tick_o, 1'b0, 0);
    endtask

    task automatic t_ctl_wave();
        tb_en = 1'b0;
        do_reset();
        for (int k = 0; k < 3 * DIV + 5; k++) begin
            chk("R2 R3 ctl_clk_o waveform", ctl_clk_o, exp_ctl(k), k);
            chk("R5 tick_o gated off", tick_o, 1'b0, k);
            @(negedge clk);
        end
    endtask

    task automatic t_timebase();
        tb_en = 1'b1;
        do_reset();
        for (int k = 0; k < 5 * HALF + 7; k++) begin
            chk("R4 tick_o square wave", tick_o, exp_sq(k), k);
            chk("R2 ctl_clk_o with timebase on", ctl_clk_o, exp_ctl(k), k);
            @(negedge clk);
        end
    endtask

    task automatic t_gating();
        tb_en = 1'b0;
        do_reset();
        for (int k = 0; k < 4 * HALF; k++) begin
            tb_en = ((k % 11) < 5);
            #1;
            chk("R5 R6 gated tick_o", tick_o, tb_en & exp_sq(k), k);
            @(negedge clk);
        end
    endtask

    task automatic t_midrun_reset();
        tb_en = 1'b1;
        do_reset();
        repeat (HALF + 7) @(negedge clk);
        do_reset();
        for (int k = 0; k < 2 * HALF + 3; k++) begin
            chk("R7 ctl_clk_o after mid-run reset", ctl_clk_o, exp_ctl(k), k);
            chk("R7 tick_o after mid-run reset", tick_o, exp_sq(k), k);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_ctl_wave();
        t_timebase();
        t_gating();
        t_midrun_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule